// File: doc/BRIEF.md
# Colour Range and Conversion Selector

This block sits beside the pixel datapath of a Full HD video receiver and tells the colour matrix which conversion to apply. It takes the decoded fields of the latest auxiliary video information frame (colour space, colorimetry, RGB quantization, YCC quantization, video code and content type), a manual range override and the output format the downstream consumer wants. From these it works out the real quantization range of the incoming video and the source colour standard. It then registers a single conversion mode code that the matrix loader decodes.

RGB leaving the receiver is always full range and YUV leaving it is always limited range. The input range follows a fixed priority: the manual override wins, then an explicit quantization value in the frame, then a default taken from the video code. The frame fields are captured when their valid strobe is seen. A later change of the override recomputes the result from the captured fields without a new frame.

Top module: `colour_conv_select`

## Requirements
- R1: `frame_cspace` 0 is RGB input and 1 to 3 are YUV input. For YUV input the source standard is 601 when `frame_colorimetry` is 1 and 709 when it is 2. For 0 or 3 the source standard follows the resolution rule of R8.
- R2: A YUV input always yields `src_full` = 0, whatever the RGB or YCC quantization fields hold.
- R3: For RGB input with override auto, `frame_rgb_q` = 2 yields `src_full` = 1 and `frame_rgb_q` = 1 yields `src_full` = 0.
- R4: For RGB input with override auto and `frame_rgb_q` of 0 or 3 (default), a video code of 0 yields full range and any other code yields limited range.
- R5: `range_force` 1 forces full range and 2 forces limited range on an RGB input, over the frame fields. Values 0 and 3 mean auto.
- R6: With `want_yuv` = 0, the mode is 0 for full RGB, 1 for limited RGB, 2 for YUV 601 and 3 for YUV 709, and `out_std_709` = 0.
- R7: With `want_yuv` = 1, the mode is 4 for full RGB to 601, 5 for full RGB to 709, 6 for limited RGB to 601, 7 for limited RGB to 709, and 8 for YUV passthrough. For passthrough, `out_std_709` equals the source standard.
- R8: A video code of 1–3, 6–15, 17–18, 21–30 or 35–38 is standard definition and selects 601. Any other code, including 0, is high definition and selects 709. This choice drives RGB-to-YUV conversion and `out_std_709`.
- R9: `content_type` equals the `frame_content` value presented with the most recent valid strobe.
- R10: The outputs change only in the cycle after a `frame_valid` strobe, or in the cycle after `range_force` differs from its previously seen value. They hold otherwise.
- R11: Reset (synchronous, `rst_n` low) gives mode 0, `src_full` = 1, `content_type` = 0 and `out_std_709` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_valid | input | 1 | One-cycle strobe: frame fields are valid |
| frame_cspace | input | 2 | Colour space field (0 RGB, else YUV) |
| frame_colorimetry | input | 2 | Colorimetry field (1 is 601, 2 is 709) |
| frame_rgb_q | input | 2 | RGB quantization field (0 default, 1 limited, 2 full, 3 default) |
| frame_ycc_q | input | 2 | YCC quantization field, not used |
| frame_vic | input | 8 | Video identification code |
| frame_content | input | 2 | Content type field |
| range_force | input | 2 | Override: 0/3 auto, 1 full, 2 limited |
| want_yuv | input | 1 | Wanted output format: 0 RGB, 1 YUV |
| conv_mode | output | 4 | Conversion mode code |
| src_full | output | 1 | Effective input range is full |
| content_type | output | 2 | Registered content type |
| out_std_709 | output | 1 | YUV output uses 709 (0 for RGB output or 601) |

## Verification
Properties checked on every cycle: outputs hold between update events, the output family follows `want_yuv`, YUV input never reports full range, a forced range lands one cycle later, and content type follows the strobe. The priority between override, explicit quantization and video-code default needs the bench's scenarios. So do the SD/HD code table, the colorimetry fallback, the insensitivity to the YCC field, and the recompute from captured fields after an override change.

// File: rtl/ccs_pkg.sv
// Shared definitions for the colour conversion selector.
// Assumes: mode codes are consumed by a matrix loader that decodes them.
package ccs_pkg;

    typedef enum logic [3:0] {
        CM_RGBF_RGBF   = 4'd0,
        CM_RGBL_RGBF   = 4'd1,
        CM_Y601_RGBF   = 4'd2,
        CM_Y709_RGBF   = 4'd3,
        CM_RGBF_Y601   = 4'd4,
        CM_RGBF_Y709   = 4'd5,
        CM_RGBL_Y601   = 4'd6,
        CM_RGBL_Y709   = 4'd7,
        CM_YUV_PASS    = 4'd8
    } conv_mode_e;

    localparam logic [1:0] FORCE_FULL  = 2'd1;
    localparam logic [1:0] FORCE_LIM   = 2'd2;
    localparam logic [1:0] QUANT_LIM   = 2'd1;
    localparam logic [1:0] QUANT_FULL  = 2'd2;
    localparam logic [1:0] CMTRY_601   = 2'd1;
    localparam logic [1:0] CMTRY_709   = 2'd2;

endpackage

// File: rtl/ccs_std_pick.sv
// Classifies the input colour space and picks the source and resolution standards.
// Assumes: colour space 0 is RGB, every other code is YUV; standard-definition
// video codes are the 480/576 line families listed in the requirements.
module ccs_std_pick #(
    parameter int VIC_W = 8
) (
    input  logic [1:0]       cspace,
    input  logic [1:0]       colorimetry,
    input  logic [VIC_W-1:0] vic,
    output logic             is_rgb,
    output logic             res_hd,
    output logic             src_709
);
    import ccs_pkg::*;

    logic sd_code;

    // Decide whether the video code names a standard-definition mode.
    always_comb begin
        sd_code = ((vic >= VIC_W'(1))  && (vic <= VIC_W'(3)))  ||
                  ((vic >= VIC_W'(6))  && (vic <= VIC_W'(15))) ||
                  ((vic >= VIC_W'(17)) && (vic <= VIC_W'(18))) ||
                  ((vic >= VIC_W'(21)) && (vic <= VIC_W'(30))) ||
                  ((vic >= VIC_W'(35)) && (vic <= VIC_W'(38)));
    end

    // Derive format class and standards from the frame fields.
    always_comb begin
        is_rgb = (cspace == 2'd0);
        res_hd = !sd_code;
        if (colorimetry == CMTRY_709)      src_709 = 1'b1;
        else if (colorimetry == CMTRY_601) src_709 = 1'b0;
        else                               src_709 = res_hd;
    end

endmodule

// File: rtl/ccs_range_resolve.sv
// Resolves the effective quantization range of the incoming video.
// Priority: YUV is limited; else override; else explicit field; else code default.
module ccs_range_resolve (
    input  logic       is_rgb,
    input  logic [1:0] rgb_q,
    input  logic       vic_zero,
    input  logic [1:0] force_sel,
    output logic       full
);
    import ccs_pkg::*;

    // Apply the ordered range rule.
    always_comb begin
        if (!is_rgb)                   full = 1'b0;
        else if (force_sel == FORCE_FULL) full = 1'b1;
        else if (force_sel == FORCE_LIM)  full = 1'b0;
        else if (rgb_q == QUANT_FULL)  full = 1'b1;
        else if (rgb_q == QUANT_LIM)   full = 1'b0;
        else                           full = vic_zero;
    end

endmodule

// File: rtl/ccs_mode_encode.sv
// Turns format class, range, standards and output choice into a mode code.
// Assumes: RGB output is full range, YUV output is limited range.
module ccs_mode_encode (
    input  logic       is_rgb,
    input  logic       full,
    input  logic       src_709,
    input  logic       res_hd,
    input  logic       want_yuv,
    output logic [3:0] mode,
    output logic       out_709
);
    import ccs_pkg::*;

    conv_mode_e m;

    // Select the conversion for the requested output family.
    always_comb begin
        out_709 = 1'b0;
        if (!want_yuv) begin
            if (is_rgb) m = full ? CM_RGBF_RGBF : CM_RGBL_RGBF;
            else        m = src_709 ? CM_Y709_RGBF : CM_Y601_RGBF;
        end else if (is_rgb) begin
            out_709 = res_hd;
            if (full) m = res_hd ? CM_RGBF_Y709 : CM_RGBF_Y601;
            else      m = res_hd ? CM_RGBL_Y709 : CM_RGBL_Y601;
        end else begin
            out_709 = src_709;
            m = CM_YUV_PASS;
        end
        mode = m;
    end

endmodule

// File: rtl/colour_conv_select.sv
// Top of the colour conversion selector. Captures frame fields on a valid
// strobe and registers the mode, range, standard and content type. An
// override change recomputes from the captured fields.
// Assumes: frame_valid is a one-cycle strobe; synchronous active-low reset.
module colour_conv_select #(
    parameter int VIC_W = 8,
    parameter int CT_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic [1:0]       frame_cspace,
    input  logic [1:0]       frame_colorimetry,
    input  logic [1:0]       frame_rgb_q,
    input  logic [1:0]       frame_ycc_q,
    input  logic [VIC_W-1:0] frame_vic,
    input  logic [CT_W-1:0]  frame_content,
    input  logic [1:0]       range_force,
    input  logic             want_yuv,
    output logic [3:0]       conv_mode,
    output logic             src_full,
    output logic [CT_W-1:0]  content_type,
    output logic             out_std_709
);
    import ccs_pkg::*;

    logic [1:0]       cap_cspace, cap_cmtry, cap_q;
    logic [VIC_W-1:0] cap_vic;
    logic [1:0]       force_q;
    logic [1:0]       sel_cspace, sel_cmtry, sel_q;
    logic [VIC_W-1:0] sel_vic;
    logic             upd, force_chg;
    logic             is_rgb, res_hd, src_709, full_n, out709_n;
    logic [3:0]       mode_n;
    logic             ycc_unused;

    // The YCC quantization field never affects the result.
    assign ycc_unused = ^frame_ycc_q;

    // Detect an override change and pick live or captured fields.
    always_comb begin
        force_chg  = (range_force != force_q);
        upd        = frame_valid || force_chg;
        sel_cspace = frame_valid ? frame_cspace      : cap_cspace;
        sel_cmtry  = frame_valid ? frame_colorimetry : cap_cmtry;
        sel_q      = frame_valid ? frame_rgb_q       : cap_q;
        sel_vic    = frame_valid ? frame_vic         : cap_vic;
    end

    ccs_std_pick #(.VIC_W(VIC_W)) u_std (
        .cspace      (sel_cspace),
        .colorimetry (sel_cmtry),
        .vic         (sel_vic),
        .is_rgb      (is_rgb),
        .res_hd      (res_hd),
        .src_709     (src_709)
    );

    ccs_range_resolve u_range (
        .is_rgb    (is_rgb),
        .rgb_q     (sel_q),
        .vic_zero  (sel_vic == '0),
        .force_sel (range_force),
        .full      (full_n)
    );

    ccs_mode_encode u_enc (
        .is_rgb   (is_rgb),
        .full     (full_n),
        .src_709  (src_709),
        .res_hd   (res_hd),
        .want_yuv (want_yuv),
        .mode     (mode_n),
        .out_709  (out709_n)
    );

    // Capture frame fields on the strobe and track the override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_cspace <= '0;
            cap_cmtry  <= '0;
            cap_q      <= '0;
            cap_vic    <= '0;
            force_q    <= '0;
        end else begin
            force_q <= range_force;
            if (frame_valid) begin
                cap_cspace <= frame_cspace;
                cap_cmtry  <= frame_colorimetry;
                cap_q      <= frame_rgb_q;
                cap_vic    <= frame_vic;
            end
        end
    end

    // Register the results on an update event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_mode    <= 4'(CM_RGBF_RGBF);
            src_full     <= 1'b1;
            content_type <= '0;
            out_std_709  <= 1'b0;
        end else begin
            if (upd) begin
                conv_mode   <= mode_n;
                src_full    <= full_n;
                out_std_709 <= out709_n;
            end
            if (frame_valid) content_type <= frame_content;
        end
    end

    // R10: no update event means every output holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !force_chg) |=>
            ($stable(conv_mode) && $stable(src_full) && $stable(out_std_709) && $stable(content_type)));

    // R6 and R7: the output family follows the wanted format.
    a_r6_rgb_family: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !want_yuv) |=> (conv_mode <= 4'd3 && !out_std_709));
    a_r7_yuv_family: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && want_yuv) |=> (conv_mode >= 4'd4 && conv_mode <= 4'd8));

    // R2: a YUV frame never reports full range.
    a_r2_yuv_limited: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_cspace != 2'd0) |=> !src_full);

    // R5: forcing full range on an RGB frame lands one cycle later.
    a_r5_force_full: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_cspace == 2'd0 && range_force == FORCE_FULL) |=> src_full);

    // R9: content type follows the strobe.
    a_r9_content: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> (content_type == $past(frame_content)));

endmodule

// File: tb/tb_colour_conv_select.sv
module tb_colour_conv_select;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_valid = 1'b0;
    logic [1:0] frame_cspace = '0, frame_colorimetry = '0, frame_rgb_q = '0, frame_ycc_q = '0;
    logic [7:0] frame_vic = '0;
    logic [1:0] frame_content = '0;
    logic [1:0] range_force = '0;
    logic       want_yuv = 1'b0;
    logic [3:0] conv_mode;
    logic       src_full;
    logic [1:0] content_type;
    logic       out_std_709;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model state
    logic [1:0] m_cs, m_cm, m_q, m_force_prev, m_ct;
    logic [7:0] m_vic;
    logic [3:0] e_mode;
    logic       e_full, e_709;
    string      last_tag;

    colour_conv_select dut (.*);

    always #2.5 clk = ~clk;

    function automatic bit is_sd(input logic [7:0] v);
        return (v >= 1 && v <= 3) || (v >= 6 && v <= 15) || (v == 17) || (v == 18) ||
               (v >= 21 && v <= 30) || (v >= 35 && v <= 38);
    endfunction

    // Expected results from the requirements; tag names the deciding rule.
    task automatic expect_of(input logic [1:0] cs, cm, q, input logic [7:0] vic,
                             input logic [1:0] frc, input logic oy);
        bit rgb, hd, s709, full;
        rgb  = (cs == 0);
        hd   = !is_sd(vic);
        s709 = (cm == 2) ? 1'b1 : (cm == 1) ? 1'b0 : hd;
        if (!rgb)          begin full = 0; last_tag = "R2"; end
        else if (frc == 1) begin full = 1; last_tag = "R5"; end
        else if (frc == 2) begin full = 0; last_tag = "R5"; end
        else if (q == 2)   begin full = 1; last_tag = "R3"; end
        else if (q == 1)   begin full = 0; last_tag = "R3"; end
        else               begin full = (vic == 0); last_tag = "R4"; end
        e_full = full;
        if (!oy) begin
            e_709  = 0;
            e_mode = rgb ? (full ? 4'd0 : 4'd1) : (s709 ? 4'd3 : 4'd2);
        end else if (rgb) begin
            e_709  = hd;
            e_mode = (full ? 4'd4 : 4'd6) + {3'd0, hd};
        end else begin
            e_709  = s709;
            e_mode = 4'd8;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp_v);
        n_vec++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp_v, $time);
        end
    endtask

    // One cycle: inputs already driven; update model at the edge, compare after it.
    task automatic step(input string hold_tag);
        bit ev;
        @(posedge clk);
        ev = frame_valid || (range_force != m_force_prev);
        if (frame_valid) begin
            m_cs = frame_cspace; m_cm = frame_colorimetry; m_q = frame_rgb_q;
            m_vic = frame_vic; m_ct = frame_content;
        end
        m_force_prev = range_force;
        if (ev) expect_of(m_cs, m_cm, m_q, m_vic, range_force, want_yuv);
        #1;
        if (ev) begin
            chk(want_yuv ? "R7" : "R6", conv_mode, e_mode);
            chk(last_tag, src_full, e_full);
            chk((want_yuv && m_cs == 0) ? "R8" : "R1", out_std_709, e_709);
        end else begin
            chk(hold_tag, conv_mode, e_mode);
            chk(hold_tag, src_full, e_full);
            chk(hold_tag, out_std_709, e_709);
        end
        chk("R9", content_type, m_ct);
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic frame(input logic [1:0] cs, cm, q, ycc, input logic [7:0] vic,
                         input logic [1:0] ct, frc, input logic oy, input string hold_tag);
        frame_cspace = cs; frame_colorimetry = cm; frame_rgb_q = q; frame_ycc_q = ycc;
        frame_vic = vic; frame_content = ct; range_force = frc; want_yuv = oy;
        frame_valid = 1'b1;
        step(hold_tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R11: reset with busy inputs
        frame_cspace = 2'd1; frame_vic = 8'd16; frame_content = 2'd3; want_yuv = 1'b1;
        repeat (3) @(negedge clk);
        #0;
        chk("R11", conv_mode, 0);
        chk("R11", src_full, 1);
        chk("R11", content_type, 0);
        chk("R11", out_std_709, 0);
        m_cs = 0; m_cm = 0; m_q = 0; m_vic = 0; m_ct = 0; m_force_prev = 0;
        e_mode = 0; e_full = 1; e_709 = 0;
        range_force = 2'd0;
        rst_n = 1'b1;

        // Directed corners
        frame(2'd0, 2'd0, 2'd0, 2'd2, 8'd0,  2'd1, 2'd0, 1'b0, "R10"); // R4 vic 0 full
        frame(2'd0, 2'd0, 2'd3, 2'd0, 8'd16, 2'd2, 2'd0, 1'b0, "R10"); // R4 reserved q
        frame(2'd0, 2'd0, 2'd2, 2'd0, 8'd16, 2'd0, 2'd0, 1'b1, "R10"); // R3 explicit full
        frame(2'd0, 2'd0, 2'd1, 2'd0, 8'd0,  2'd0, 2'd0, 1'b1, "R10"); // R3 explicit limited
        frame(2'd2, 2'd0, 2'd2, 2'd2, 8'd3,  2'd0, 2'd0, 1'b1, "R10"); // R1 SD fallback, R2
        frame(2'd1, 2'd2, 2'd2, 2'd1, 8'd3,  2'd0, 2'd0, 1'b0, "R10"); // R1 709 colorimetry
        frame(2'd0, 2'd0, 2'd2, 2'd0, 8'd38, 2'd0, 2'd2, 1'b1, "R10"); // R5 force limited, R8 SD edge
        frame(2'd0, 2'd0, 2'd1, 2'd0, 8'd39, 2'd0, 2'd1, 1'b1, "R10"); // R5 force full, R8 HD edge
        // R10: fields change without strobe, outputs hold
        frame_cspace = 2'd1; frame_rgb_q = 2'd1; frame_vic = 8'd5; frame_content = 2'd3;
        step("R10"); step("R10");
        // R5 and R10: override change recomputes from captured fields
        range_force = 2'd0; step("R10");
        range_force = 2'd3; step("R10");
        // R2: YCC field alone does not matter
        frame(2'd1, 2'd1, 2'd0, 2'd2, 8'd4, 2'd0, 2'd0, 1'b0, "R10");
        frame(2'd1, 2'd1, 2'd0, 2'd1, 8'd4, 2'd0, 2'd0, 1'b0, "R10");

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            int pick;
            frame_cspace      = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            frame_colorimetry = 2'($urandom_range(0, 3));
            frame_rgb_q       = 2'($urandom_range(0, 3));
            frame_ycc_q       = 2'($urandom_range(0, 3));
            pick = $urandom_range(0, 3);
            frame_vic = (pick == 0) ? 8'd0 : (pick == 1) ? 8'($urandom_range(1, 40))
                      : (pick == 2) ? 8'd16 : 8'($urandom_range(0, 255));
            frame_content = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) range_force = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0) want_yuv = ~want_yuv;
            frame_valid = ($urandom_range(0, 2) == 0);
            step("R10");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule